// File: doc/BRIEF.md
# Control-Byte Command Stream Decoder

This block sits behind a write-only three-wire serial link: an active-low chip enable, a serial clock and a serial data input. It has no output line. Every pin is brought into the local clock domain and oversampled. Data is taken on each rising edge of the serial clock and shifted into bytes, most significant bit first. Whenever chip enable is high, the bit counter and the frame state return to their idle values. A transfer ends when chip enable goes high.

The first byte of each transfer is an address byte, and it is checked. If the address byte matches, the next byte is a control byte. The control byte chooses where the data bytes that follow are sent: the command consumer, the display RAM consumer or the PWM register consumer. The control byte also says what comes after the data:

- If its continuation bit is set, one data byte follows and then another control byte.
- If its continuation bit is clear, every byte until the transfer ends is data.

Each data byte that is decoded raises exactly one typed strobe for one clock cycle, with the byte value on a shared data output.

Top module: `cbyte_stream_decoder`

## Requirements
- R1: While chip enable is high, the bit count and the frame state are cleared. A partial byte left over from one transfer therefore never combines with bits from the next transfer.
- R2: Serial bits are sampled on rising serial-clock edges and are assembled most significant bit first.
- R3: The first byte of a transfer is accepted only if bit 7 is 0 and bits 6 to 4 equal 001. Bits 3 to 0 are don't-care. With any other value, the block raises no strobe until the transfer ends.
- R4: A control byte never raises a strobe. If its bit 7 (continuation) is 1, exactly one data byte is routed, and the byte after that is decoded as a new control byte.
- R5: If the continuation bit is 0, every later byte of the transfer is routed as data under the same selection.
- R6: Control bits 6 to 5 pick the destination: 00 selects the command strobe, 01 the RAM strobe and 10 the PWM strobe. Bits 4 to 0 are ignored.
- R7: Selection 11 is reserved. Data bytes under it raise no strobe, but they are still counted for framing, so a continuation control byte under selection 11 is still followed by a new control byte.
- R8: Each routed byte produces a strobe that is one cycle wide. At most one strobe is high in any cycle, and the byte value is on the data output while its strobe is high.
- R9: After a synchronous reset, all strobes are low and the data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| ser_cs_n | input | 1 | Active-low chip enable of the link |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data input |
| cmd_stb | output | 1 | One-cycle strobe for a command byte |
| ram_stb | output | 1 | One-cycle strobe for a display RAM byte |
| pwm_stb | output | 1 | One-cycle strobe for a PWM register byte |
| byte_out | output | 8 | Value of the most recently routed byte |

## Verification
The bench drives mixed frames:

- **Alternating frames.** Control/data pairs are followed by a final run. A decoder that treated every byte after the first control byte as data would emit the second control byte as a data strobe.
- **Bad address bytes.** One frame has a bad read/write bit and one has a bad fixed field. A decoder that checked only part of the address would route the RAM data that follows. A frame with a set low nibble catches a decoder that checks too many bits.
- **Reserved selection with continuation.** A decoder that dropped the framing along with the reserved byte would lose the command that follows.
- **Truncated byte.** A transfer is cut off in the middle of a byte and followed by a new transfer. A decoder that did not clear its bit counter on chip enable would misalign every later byte.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

    localparam int BYTE_W = 8;
    localparam logic [2:0] ADDR_FIXED = 3'b001;

    typedef enum logic [2:0] {
        FS_ADDR,
        FS_CTRL,
        FS_SINGLE,
        FS_STREAM,
        FS_DROP
    } frame_state_t;

    typedef enum logic [1:0] {
        DST_CMD = 2'b00,
        DST_RAM = 2'b01,
        DST_PWM = 2'b10,
        DST_RSV = 2'b11
    } dest_t;

    typedef struct packed {
        logic              cmd;
        logic              ram;
        logic              pwm;
        logic [BYTE_W-1:0] value;
    } route_out_t;

    function automatic logic addr_ok(input logic [BYTE_W-1:0] b);
        return (b[7] == 1'b0) && (b[6:4] == ADDR_FIXED);
    endfunction

    function automatic dest_t ctrl_dest(input logic [BYTE_W-1:0] b);
        return dest_t'(b[6:5]);
    endfunction

    function automatic logic ctrl_more(input logic [BYTE_W-1:0] b);
        return b[7];
    endfunction

endpackage

// File: rtl/cbd_sync.sv
module cbd_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cbd_shifter.sv
module cbd_shifter
    import cbd_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_hi,
    input  logic          sck_s,
    input  logic          sdi_s,
    output logic          byte_vld,
    output logic [DW-1:0] byte_val
);
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

    logic             sck_prev;
    logic             sck_rise;
    logic [DW-2:0]    shreg;
    logic [CNT_W-1:0] bit_cnt;

    assign sck_rise = sck_s & ~sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            shreg    <= '0;
            bit_cnt  <= '0;
            byte_vld <= 1'b0;
            byte_val <= '0;
        end else begin
            sck_prev <= sck_s;
            byte_vld <= 1'b0;
            if (cs_hi) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[DW-3:0], sdi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST) begin
                    byte_vld <= 1'b1;
                    byte_val <= {shreg, sdi_s};
                end
            end
        end
    end

    p_cnt_clear_r1: assert property (@(posedge clk) disable iff (rst)
        cs_hi |=> (bit_cnt == '0));

    p_no_byte_idle_r1: assert property (@(posedge clk) disable iff (rst)
        cs_hi |=> !byte_vld);
endmodule

// File: rtl/cbd_framer.sv
module cbd_framer
    import cbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_hi,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    output route_out_t        route
);
    frame_state_t state;
    dest_t        dest;
    logic         emit;
    logic         any_stb;

    assign emit    = byte_vld && !cs_hi && (state == FS_SINGLE || state == FS_STREAM);
    assign any_stb = route.cmd | route.ram | route.pwm;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_ADDR;
            dest  <= DST_CMD;
            route <= '0;
        end else begin
            route.cmd <= 1'b0;
            route.ram <= 1'b0;
            route.pwm <= 1'b0;
            if (cs_hi) begin
                state <= FS_ADDR;
            end else if (byte_vld) begin
                case (state)
                    FS_ADDR:   state <= addr_ok(byte_val) ? FS_CTRL : FS_DROP;
                    FS_CTRL: begin
                        dest  <= ctrl_dest(byte_val);
                        state <= ctrl_more(byte_val) ? FS_SINGLE : FS_STREAM;
                    end
                    FS_SINGLE: state <= FS_CTRL;
                    default:   state <= state;
                endcase
            end
            if (emit && dest != DST_RSV) begin
                route.value <= byte_val;
                case (dest)
                    DST_CMD: route.cmd <= 1'b1;
                    DST_RAM: route.ram <= 1'b1;
                    DST_PWM: route.pwm <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    p_onehot_stb_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({route.cmd, route.ram, route.pwm}));

    p_stb_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        any_stb |=> !any_stb);

    p_drop_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && state == FS_DROP) |=> !any_stb);

    p_ctrl_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && state == FS_CTRL) |=> !any_stb);

    p_rsv_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && dest == DST_RSV && state != FS_CTRL) |=> !any_stb);

    p_cs_idle_r1: assert property (@(posedge clk) disable iff (rst)
        cs_hi |=> (state == FS_ADDR));
endmodule

// File: rtl/cbyte_stream_decoder.sv
module cbyte_stream_decoder
    import cbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_cs_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              cmd_stb,
    output logic              ram_stb,
    output logic              pwm_stb,
    output logic [BYTE_W-1:0] byte_out
);
    logic [2:0]        pins_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;
    route_out_t        route;

    cbd_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_cs_n, ser_clk, ser_din}),
        .q   (pins_s)
    );

    cbd_shifter #(.DW(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .cs_hi    (pins_s[2]),
        .sck_s    (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .byte_vld (byte_vld),
        .byte_val (byte_val)
    );

    cbd_framer u_frame (
        .clk      (clk),
        .rst      (rst),
        .cs_hi    (pins_s[2]),
        .byte_vld (byte_vld),
        .byte_val (byte_val),
        .route    (route)
    );

    assign cmd_stb  = route.cmd;
    assign ram_stb  = route.ram;
    assign pwm_stb  = route.pwm;
    assign byte_out = route.value;
endmodule

// File: tb/cbyte_stream_decoder_test.sv
module cbyte_stream_decoder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_cs_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       cmd_stb, ram_stb, pwm_stb;
    logic [7:0] byte_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [1:0] ev_t [16];
    logic [7:0] ev_b [16];
    int         ev_n = 0;
    int         multi = 0;

    always #4 clk = ~clk;

    cbyte_stream_decoder uut (
        .clk(clk), .rst(rst), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .cmd_stb(cmd_stb), .ram_stb(ram_stb),
        .pwm_stb(pwm_stb), .byte_out(byte_out)
    );

    // event log, sampled on the falling clock edge; type 1 cmd, 2 ram, 3 pwm
    always @(negedge clk) begin
        if (!rst) begin
            if ((32'(cmd_stb) + 32'(ram_stb) + 32'(pwm_stb)) > 1) multi++;
            if ((cmd_stb || ram_stb || pwm_stb) && ev_n < 16) begin
                ev_t[ev_n] = cmd_stb ? 2'd1 : (ram_stb ? 2'd2 : 2'd3);
                ev_b[ev_n] = byte_out;
                ev_n++;
            end
        end
    end

    localparam int NV = 9;
    localparam logic [47:0] TX_BYTES [NV] = '{
        48'h10_20_AA_55_00_00,
        48'h10_80_3C_20_11_22,
        48'h10_C0_7F_40_01_00,
        48'h90_20_AA_00_00_00,
        48'h1F_60_11_22_00_00,
        48'h30_20_AA_00_00_00,
        48'h1F_E0_99_80_42_00,
        48'h10_A0_00_00_00_00,
        48'h10_00_00_00_00_00
    };
    localparam int TX_LEN [NV] = '{4, 6, 5, 3, 4, 3, 5, 2, 1};
    localparam int EXP_N  [NV] = '{2, 3, 2, 0, 0, 0, 1, 0, 0};
    localparam logic [39:0] EXP_EV [NV] = '{
        {10'h2AA, 10'h255, 10'h000, 10'h000},
        {10'h13C, 10'h211, 10'h222, 10'h000},
        {10'h37F, 10'h301, 10'h000, 10'h000},
        40'h0, 40'h0, 40'h0,
        {10'h142, 10'h000, 10'h000, 10'h000},
        40'h0, 40'h0
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R5 R6 R2 ram run";
            1: return "R4 R5 R6 cmd pair then ram run";
            2: return "R4 R6 pwm pair then run";
            3: return "R3 bad rw bit";
            4: return "R7 R3 reserved run, low nibble ignored";
            5: return "R3 bad fixed field";
            6: return "R7 R4 reserved pair then cmd";
            7: return "R4 control byte alone";
            default: return "R3 address byte alone";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int k = 7; k > 7 - n; k--) begin
            @(negedge clk); ser_din = b[k];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic cs_low();
        @(negedge clk); ser_cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (6) @(negedge clk);
        ser_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(!cmd_stb && !ram_stb && !pwm_stb, "R9 strobes after reset",
              {cmd_stb, ram_stb, pwm_stb}, 0);
        check(byte_out == 8'h00, "R9 byte_out after reset", byte_out, 0);

        for (int v = 0; v < NV; v++) begin
            ev_n = 0;
            cs_low();
            for (int i = 0; i < TX_LEN[v]; i++) send_bits(TX_BYTES[v][47-8*i -: 8], 8);
            cs_high();
            check(ev_n == EXP_N[v], {vec_tag(v), " strobe count"}, ev_n, EXP_N[v]);
            for (int e = 0; e < EXP_N[v] && e < ev_n; e++)
                check({ev_t[e], ev_b[e]} == EXP_EV[v][39-10*e -: 10],
                      {vec_tag(v), " routed byte"}, {ev_t[e], ev_b[e]},
                      EXP_EV[v][39-10*e -: 10]);
        end

        // R1: a transfer cut mid-byte must not disturb the next one
        ev_n = 0;
        cs_low();
        send_bits(8'h10, 8); send_bits(8'h00, 8); send_bits(8'hE0, 3);
        cs_high();
        check(ev_n == 0, "R1 partial byte dropped", ev_n, 0);
        cs_low();
        send_bits(8'h10, 8); send_bits(8'h00, 8); send_bits(8'h5A, 8);
        cs_high();
        check(ev_n == 1, "R1 count after truncated transfer", ev_n, 1);
        if (ev_n >= 1)
            check({ev_t[0], ev_b[0]} == 10'h15A, "R1 R2 byte after truncated transfer",
                  {ev_t[0], ev_b[0]}, 10'h15A);

        // R8: never two strobes at once, data still held after strobe
        check(multi == 0, "R8 overlapping strobes", multi, 0);
        check(byte_out == 8'h5A && !cmd_stb, "R8 byte held, strobe low",
              byte_out, 8'h5A);

        // R9: reset mid-stream clears the outputs
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(byte_out == 8'h00 && !cmd_stb && !ram_stb && !pwm_stb,
              "R9 outputs after second reset", byte_out, 0);
        rst = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule